// File: doc/BRIEF.md
# DMA Request Enable Clear-Command Register

This block holds the per-channel DMA request enable vector of a DMA controller and gives software a byte-wide, write-only command port for turning enables off. Software writes one command byte that names a channel number, not a bit mask. The byte clears that channel's enable, clears every enable at once, or, when its no-op flag is set, does nothing. The no-op flag lets software write several command bytes in one 32-bit store and leave the neighbouring commands idle.

The enable vector is loaded from a direct-write port, `ld_we` and `ld_data`. This port stands in for whatever sets enables in the wider controller. The vector drives `req_en` from flops. The bus side is a small register interface of 32-bit words with byte strobes, and it uses big-endian byte and bit numbering. A read of either enable word returns the live vector. A read of the command word returns zeros. The build is either 64 channels or 32 channels, chosen by `NUM_CH`.

Top module: `dma_req_enable_ctl`

## Requirements
- R1: `rst` is synchronous and active high. At the clock edge where `rst` is high, `req_en` becomes all zeros and `bus_rdata` becomes zero.
- R2: At a clock edge with `ld_we` high, `req_en` takes the value of `ld_data`, except for bits that a clear command removes in the same cycle.
- R3: The command byte is at byte offset 1 of word address 2. It is `bus_wdata[23:16]` and is strobed by `bus_be[2]`. Its MSB, `bus_wdata[23]`, is the no-op flag. The low seven bits, `bus_wdata[22:16]`, are the code. When the flag is 0 and the code is below `NUM_CH`, the next edge clears only `req_en[code]`.
- R4: When the flag is 0 and code bit 6 (`bus_wdata[22]`) is set, so the code is 64 to 127, the next edge clears every bit of `req_en`.
- R5: When the no-op flag is 1, the whole command byte is ignored, whatever its code.
- R6: A write to word 2 with `bus_be[2]` low changes nothing. Other byte lanes of word 2 never affect the enable vector, including when they are written in the same word store as a valid command.
- R7: When a load and a clear command hit the same channel in the same cycle, the clear wins.
- R8: In the 32-channel build, a code from 32 to 63 names no channel and changes nothing.
- R9: A read (`bus_rd`) returns data on `bus_rdata` at the next edge. Word 0 holds `req_en[31:0]`. Word 1 holds `req_en[63:32]`, or zero in the 32-channel build. Words 2 and 3 read as zero. Without a read, `bus_rdata` returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_be | input | 4 | Byte strobes; `bus_be[3]` is byte offset 0 |
| bus_wdata | input | 32 | Write data, big-endian byte order |
| bus_rdata | output | 32 | Registered read data |
| ld_we | input | 1 | Direct load of the enable vector |
| ld_data | input | NUM_CH | Value loaded into the enable vector |
| req_en | output | NUM_CH | Per-channel DMA request enables |

## Verification
A wrong decode of the command byte shows on `req_en` one edge after the write. The symptom is a wrong bit clearing, a surviving bit, or a vector wiped by a byte that should have been ignored. The bench compares the whole vector after every step, so a stray change in an unrelated channel is caught as well as the intended one. A wrong read selection or a stale hold shows on `bus_rdata` one edge after the read strobe. The 32-channel build is run next to the 64-channel build under the same stimulus, so codes above its channel count are seen to be harmless.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  // Bus word width and the byte offset of the clear command inside its word.
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CMD_OFS  = 1;
  localparam int unsigned LANES    = WORD_W / 8;

  // Word map of the register window.
  typedef enum logic [1:0] {
    SEL_EN_LO = 2'd0,
    SEL_EN_HI = 2'd1,
    SEL_CMD   = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  // Decoded clear request handed from the decoder to the enable bank.
  typedef struct packed {
    logic       clr_one;
    logic       clr_all;
    logic [5:0] chan;
  } clr_req_t;

endpackage

// File: rtl/dma_clr_cmd_decode.sv
module dma_clr_cmd_decode
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic                wr,
  input  logic [1:0]          addr,
  input  logic [LANES-1:0]    be,
  input  logic [WORD_W-1:0]   wdata,
  output clr_req_t            req
);

  // Big-endian lanes: offset k sits in the k-th byte from the top.
  localparam int unsigned STRB_IDX = LANES - 1 - CMD_OFS;
  localparam int unsigned BYTE_TOP = WORD_W - 1 - 8 * CMD_OFS;

  logic       lane_hit;
  logic [7:0] cmd_byte;
  logic       noop;
  logic [6:0] code;
  logic       in_range;

  always_comb begin
    lane_hit = wr && (addr == SEL_CMD) && be[STRB_IDX];
    cmd_byte = wdata[BYTE_TOP -: 8];
    noop     = cmd_byte[7];          // big-endian bit 0
    code     = cmd_byte[6:0];
    in_range = int'(code[5:0]) < int'(NUM_CH);
    req.clr_all = lane_hit && !noop && code[6];
    req.clr_one = lane_hit && !noop && !code[6] && in_range;
    req.chan    = code[5:0];
  end

endmodule

// File: rtl/dma_en_bank.sv
module dma_en_bank
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [NUM_CH-1:0] ld_data,
  input  clr_req_t          req,
  output logic [NUM_CH-1:0] en_q
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = req.clr_all || (req.clr_one && (req.chan == 6'(g)));

    always_ff @(posedge clk) begin
      if (rst)        en_q[g] <= 1'b0;
      else if (hit)   en_q[g] <= 1'b0;       // clear beats load
      else if (ld_we) en_q[g] <= ld_data[g];
    end
  end

endmodule

// File: rtl/dma_reg_read.sv
module dma_reg_read
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [NUM_CH-1:0] en,
  output logic [WORD_W-1:0] rdata
);

  localparam bit HAS_HI = NUM_CH > WORD_W;

  logic [WORD_W-1:0] lo_word;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] sel_word;

  assign lo_word = en[WORD_W-1:0];

  if (HAS_HI) begin : g_hi
    assign hi_word = WORD_W'(en[NUM_CH-1:WORD_W]);
  end else begin : g_no_hi
    assign hi_word = '0;
  end

  always_comb begin
    unique case (addr)
      SEL_EN_LO: sel_word = lo_word;
      SEL_EN_HI: sel_word = hi_word;
      default:   sel_word = '0;   // command word is write-only
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel_word;
    else         rdata <= '0;
  end

endmodule

// File: rtl/dma_req_enable_ctl.sv
module dma_req_enable_ctl
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ld_we,
  input  logic [NUM_CH-1:0] ld_data,
  output logic [NUM_CH-1:0] req_en
);

  clr_req_t clr_req;

  dma_clr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr    (bus_wr),
    .addr  (bus_addr),
    .be    (bus_be),
    .wdata (bus_wdata),
    .req   (clr_req)
  );

  dma_en_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (ld_we),
    .ld_data (ld_data),
    .req     (clr_req),
    .en_q    (req_en)
  );

  dma_reg_read #(.NUM_CH(NUM_CH)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .en    (req_en),
    .rdata (bus_rdata)
  );

endmodule

// File: rtl/dma_req_enable_ctl_chk.sv
module dma_req_enable_ctl_chk #(
  parameter int unsigned NUM_CH = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ld_we,
  input logic [NUM_CH-1:0] ld_data,
  input logic [NUM_CH-1:0] req_en
);

  logic       cmd_word;
  logic       lane;
  logic [7:0] cbyte;

  assign cmd_word = bus_wr && (bus_addr == 2'd2);
  assign lane     = cmd_word && bus_be[2];
  assign cbyte    = bus_wdata[23:16];

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (req_en == '0 && bus_rdata == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_we && !lane) |=> (req_en == $past(ld_data)));

  // R3 and R7: a named channel is off after the edge even if loaded alongside.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_one
    p_clear_one_r3: assert property (@(posedge clk) disable iff (rst)
      (lane && !cbyte[7] && !cbyte[6] && cbyte[5:0] == 6'(g)) |=> !req_en[g]);
  end

  p_clear_all_r4: assert property (@(posedge clk) disable iff (rst)
    (lane && !cbyte[7] && cbyte[6]) |=> (req_en == '0));

  p_noop_r5: assert property (@(posedge clk) disable iff (rst)
    (lane && cbyte[7] && !ld_we) |=> $stable(req_en));

  p_lane_off_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_word && !bus_be[2] && !ld_we) |=> $stable(req_en));

  p_no_channel_r8: assert property (@(posedge clk) disable iff (rst)
    (lane && !cbyte[7] && !cbyte[6] && int'(cbyte[5:0]) >= int'(NUM_CH) && !ld_we)
      |=> $stable(req_en));

  p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_addr[1]) |=> (bus_rdata == '0));

endmodule

bind dma_req_enable_ctl dma_req_enable_ctl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_dma_req_enable_ctl.sv
module test_dma_req_enable_ctl;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr, rd;
  logic [1:0]  addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic        ld_we;
  logic [63:0] ld_data;
  logic [31:0] rdata, s_rdata;
  logic [63:0] req_en;
  logic [31:0] s_req_en;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  dma_req_enable_ctl #(.NUM_CH(64)) i_dma_req_enable_ctl (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata),
    .ld_we(ld_we), .ld_data(ld_data), .req_en(req_en)
  );

  dma_req_enable_ctl #(.NUM_CH(32)) i_dma_req_enable_ctl_32 (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(s_rdata),
    .ld_we(ld_we), .ld_data(ld_data[31:0]), .req_en(s_req_en)
  );

  typedef struct packed {
    logic        ld;
    logic [63:0] ldd;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0000, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}, // R2
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h0005_0000, 64'hFFFF_FFFF_FFFF_FFDF}, // R3
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h003F_0000, 64'h7FFF_FFFF_FFFF_FFDF}, // R3
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h0087_0000, 64'h7FFF_FFFF_FFFF_FFDF}, // R5
    '{1'b0, 64'h0,                   1'b1, 4'b1011, 32'h0000_0000, 64'h7FFF_FFFF_FFFF_FFDF}, // R6
    '{1'b0, 64'h0,                   1'b1, 4'b1111, 32'h1200_3456, 64'h7FFF_FFFF_FFFF_FFDE}, // R6
    '{1'b1, 64'hA5A5_A5A5_A5A5_A5A5, 1'b1, 4'b0100, 32'h0002_0000, 64'hA5A5_A5A5_A5A5_A5A1}, // R7
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h0040_0000, 64'h0},                   // R4
    '{1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, 4'b0000, 32'h0000_0000, 64'h0123_4567_89AB_CDEF}, // R2
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h00FF_0000, 64'h0123_4567_89AB_CDEF}, // R5
    '{1'b0, 64'h0,                   1'b1, 4'b0100, 32'h007F_0000, 64'h0}                    // R4
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    wr = 1'b0; rd = 1'b0; addr = 2'd0; be = 4'b0; wdata = '0;
    ld_we = 1'b0; ld_data = '0;
  endtask

  // Command byte write at negedge; result visible at the following negedge.
  task automatic cmd(input logic [7:0] b);
    wr = 1'b1; addr = 2'd2; be = 4'b0100; wdata = {8'h00, b, 16'h0000};
    @(negedge clk);
    idle();
  endtask

  task automatic load(input logic [63:0] v);
    ld_we = 1'b1; ld_data = v;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_word(input logic [1:0] a);
    rd = 1'b1; addr = a;
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset vector", req_en, 64'h0);
    check("R1 reset vector 32ch", {32'h0, s_req_en}, 64'h0);
    check("R1 reset rdata", {32'h0, rdata}, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ld_we = VEC[i].ld; ld_data = VEC[i].ldd;
      wr = VEC[i].wr; addr = 2'd2; be = VEC[i].be; wdata = VEC[i].wd;
      @(negedge clk);
      idle();
      n_chk++;
      if (req_en !== VEC[i].exp) begin
        n_fail++;
        $display("FAIL vector %0d (R2..R7 table): got %h expected %h", i, req_en, VEC[i].exp);
      end
    end

    // R9: read paths
    load(64'h0123_4567_89AB_CDEF);
    rd_word(2'd0); check("R9 read low word", {32'h0, rdata}, 64'h89AB_CDEF);
    rd_word(2'd1); check("R9 read high word", {32'h0, rdata}, 64'h0123_4567);
    check("R9 32ch high word zero", {32'h0, s_rdata}, 64'h0);
    rd_word(2'd2); check("R9 command word reads zero", {32'h0, rdata}, 64'h0);
    rd_word(2'd3); check("R9 spare word reads zero", {32'h0, rdata}, 64'h0);
    check("R9 rdata idles at zero", {32'h0, rdata}, 64'h0);

    // R8: code 40 hits channel 40 in the 64ch build only
    cmd(8'h28);
    check("R8 32ch ignores code 40", {32'h0, s_req_en}, 64'h89AB_CDEF);
    check("R3 64ch clears channel 40", req_en, 64'h0123_4467_89AB_CDEF);

    // R3: top channel of the 32ch build
    cmd(8'h1F);
    check("R3 32ch clears channel 31", {32'h0, s_req_en}, 64'h09AB_CDEF);
    check("R3 64ch clears channel 31", req_en, 64'h0123_4467_09AB_CDEF);

    // R4: clear-all code with bit 5 set as well
    cmd(8'h60);
    check("R4 32ch clear all", {32'h0, s_req_en}, 64'h0);
    check("R4 64ch clear all", req_en, 64'h0);

    // R1: reset in the middle of operation
    load(64'hFFFF_FFFF_FFFF_FFFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset", req_en, 64'h0);
    check("R1 mid-run reset 32ch", {32'h0, s_req_en}, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule